// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block converts a 32-bit virtual byte address into a 30-bit physical address by searching a small buffer of recent page translations. Pages are 4 KB: the low 12 bits of the address pass straight through. The upper 20 bits form the virtual page number (VPN), which is compared against every stored entry at once. On a match, the stored 18-bit physical page number (PPN) is placed above the offset. Lookup is combinational, so hit, miss and the physical address are valid in the same cycle as the request.

When a lookup misses, logic outside this block walks the page table. It then returns the VPN-to-PPN pair through the fill port, and the pair is installed on the next clock edge. A fill goes to the lowest-numbered empty entry. Once the buffer is full, the fill goes to a round-robin victim. A fill whose VPN is already stored rewrites that entry, so the buffer never holds two entries for the same VPN. A flush input empties the whole buffer in one cycle, for example on a context switch.

Top module: `xlat_buffer`

## Requirements
- R1: The low 12 bits of `lk_pa` always equal the low 12 bits of `lk_va`.
- R2: The VPN is `lk_va[31:12]`. It is matched against the stored key of every valid entry, whichever slot holds it.
- R3: On a hit, `lk_pa` is `{stored PPN, lk_va[11:0]}` in the same cycle as the request. For example, VA 0x12345678 with VPN 0x12345 mapped to PPN 0x4321 gives PA 0x4321678.
- R4: `lk_miss` is high exactly when `lk_req` is high and no valid entry matches. `lk_hit` and `lk_miss` are both low when `lk_req` is low.
- R5: An invalid entry never produces a hit. After reset, every lookup misses.
- R6: When `flush` is high at a clock edge, every entry is invalid from the next cycle. A fill in that same cycle is discarded.
- R7: A fill whose VPN is already stored replaces that entry's PPN in place. No other entry changes and no duplicate is created.
- R8: A fill of a new VPN goes to the lowest-numbered invalid entry whenever one exists.
- R9: When all entries are valid, a fill of a new VPN overwrites the entry at a victim pointer. The pointer starts at 0 after reset, advances by one after each such overwrite, wraps after the last entry, and does not move on a flush.
- R10: A fill takes effect at the next clock edge. A lookup in the fill cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, invalidates all entries |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual byte address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request made, no translation found |
| lk_pa | output | 30 | Physical address, meaningful when `lk_hit` is high |
| fl_en | input | 1 | Install a translation at the next edge |
| fl_vpn | input | 20 | VPN of the translation being installed |
| fl_ppn | input | 18 | PPN of the translation being installed |
| flush | input | 1 | Invalidate every entry at the next edge |

## Verification
The bench first issues lookups on an empty buffer and lookups with the request low, which isolates the valid-bit gating from the compare. It then runs directed cases. The worked address example checks the offset splice. A fill and a lookup of the same VPN in one cycle confirm that new contents are not visible early. Filling past capacity twice, then after a flush, shows which VPN each victim evicts and so separates lowest-free placement from the round-robin pointer. A flush together with a fill shows which of the two wins. Finally, random traffic from a 16-VPN pool with random offsets mixes repeat fills, evictions and rare flushes, and every lookup result is compared with a bench model of the buffer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XL_VA_W   = 32;
  localparam int XL_PA_W   = 30;
  localparam int XL_OFF_W  = 12;
  localparam int XL_N_ENT  = 8;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N  = 8,
  parameter int KW = 20,
  parameter int DW = 18,
  localparam int IW = xlat_pkg::idx_bits(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][KW-1:0] keys,
  input  logic [N-1:0][DW-1:0] data,
  input  logic [KW-1:0]        key,
  output logic [N-1:0]         hit_vec,
  output logic                 any_hit,
  output logic [IW-1:0]        hit_idx,
  output logic [DW-1:0]        dout
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (keys[g] == key);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    dout    = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit_idx = hit_idx | IW'(i);
        dout    = dout | data[i];
      end
    end
  end

  // R7: stored keys stay unique, so at most one entry can match
  a_r7_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 8,
  localparam int IW = xlat_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  vld,
  input  logic          repl,
  output logic          full,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] free_idx;

  assign full = &vld;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign victim = full ? ptr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (repl) ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  logic [63:0] below_m;
  assign below_m = (64'd1 << victim) - 64'd1;

  // R8: with a free slot, the chosen slot is empty and every lower slot is taken
  a_r8_lowest_free: assert property (@(posedge clk) disable iff (rst)
    !full |-> (!vld[victim] && ((vld & below_m[N-1:0]) == below_m[N-1:0])));

  // R9: the round-robin pointer moves only on a replacement
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !repl |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int VA_W  = xlat_pkg::XL_VA_W,
  parameter int PA_W  = xlat_pkg::XL_PA_W,
  parameter int OFF_W = xlat_pkg::XL_OFF_W,
  parameter int N_ENT = xlat_pkg::XL_N_ENT,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IW    = xlat_pkg::idx_bits(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_pa,
  input  logic             fl_en,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PPN_W-1:0] fl_ppn,
  input  logic             flush
);
  logic [N_ENT-1:0]            vld_q;
  logic [N_ENT-1:0][VPN_W-1:0] tag_q;
  logic [N_ENT-1:0][PPN_W-1:0] ppn_q;

  // lookup path
  logic [N_ENT-1:0] lk_vec;
  logic             lk_any;
  logic [IW-1:0]    lk_idx;
  logic [PPN_W-1:0] lk_ppn;

  xlat_match #(.N(N_ENT), .KW(VPN_W), .DW(PPN_W)) u_lk_match (
    .clk(clk), .rst(rst), .vld(vld_q), .keys(tag_q), .data(ppn_q),
    .key(lk_va[VA_W-1:OFF_W]), .hit_vec(lk_vec), .any_hit(lk_any),
    .hit_idx(lk_idx), .dout(lk_ppn)
  );

  assign lk_hit  = lk_req && lk_any;
  assign lk_miss = lk_req && !lk_any;
  assign lk_pa   = {lk_ppn, lk_va[OFF_W-1:0]};

  // fill path: duplicate search
  logic [N_ENT-1:0] fl_vec;
  logic             fl_dup;
  logic [IW-1:0]    fl_idx;
  logic [PPN_W-1:0] fl_old;

  xlat_match #(.N(N_ENT), .KW(VPN_W), .DW(PPN_W)) u_fl_match (
    .clk(clk), .rst(rst), .vld(vld_q), .keys(tag_q), .data(ppn_q),
    .key(fl_vpn), .hit_vec(fl_vec), .any_hit(fl_dup),
    .hit_idx(fl_idx), .dout(fl_old)
  );

  logic          do_fill, repl, full;
  logic [IW-1:0] victim, wr_idx;

  assign do_fill = fl_en && !flush;
  assign repl    = do_fill && !fl_dup && full;
  assign wr_idx  = fl_dup ? fl_idx : victim;

  xlat_victim #(.N(N_ENT)) u_victim (
    .clk(clk), .rst(rst), .vld(vld_q), .repl(repl),
    .full(full), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (do_fill) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[wr_idx] <= fl_vpn;
      ppn_q[wr_idx] <= fl_ppn;
    end
  end

  // R6: a flush leaves no valid entry
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));

  // R10: an accepted fill is stored, valid, in the chosen slot
  a_r10_fill_lands: assert property (@(posedge clk) disable iff (rst)
    do_fill |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(fl_vpn)
                 && ppn_q[$past(wr_idx)] == $past(fl_ppn)));

  // R7: a duplicate fill keeps the occupancy unchanged
  a_r7_dup_in_place: assert property (@(posedge clk) disable iff (rst)
    (do_fill && fl_dup) |=> (vld_q == $past(vld_q)));

  // R4: hit and miss only answer a request
  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_req |-> (!lk_hit && !lk_miss));
endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req;
  logic [31:0] lk_va;
  logic        lk_hit, lk_miss;
  logic [29:0] lk_pa;
  logic        fl_en;
  logic [19:0] fl_vpn;
  logic [17:0] fl_ppn;
  logic        flush;

  always #5 clk = ~clk;

  xlat_buffer u0 (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_pa(lk_pa), .fl_en(fl_en), .fl_vpn(fl_vpn),
    .fl_ppn(fl_ppn), .flush(flush)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of the buffer contents
  bit        m_vld [N];
  bit [19:0] m_tag [N];
  bit [17:0] m_ppn [N];
  int        m_ptr;

  function automatic void m_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endfunction

  function automatic bit m_find(input bit [19:0] vpn, output int idx);
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && m_tag[i] == vpn) begin
        idx = i;
        return 1'b1;
      end
    end
    idx = -1;
    return 1'b0;
  endfunction

  function automatic void m_fill(input bit [19:0] vpn, input bit [17:0] ppn);
    int w;
    if (!m_find(vpn, w)) begin
      w = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) w = i;
      if (w < 0) begin
        w = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    m_vld[w] = 1'b1;
    m_tag[w] = vpn;
    m_ppn[w] = ppn;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_req = 1'b0; lk_va = '0; fl_en = 1'b0; fl_vpn = '0; fl_ppn = '0; flush = 1'b0;
  endtask

  // drive a lookup after the falling edge and compare with the model
  task automatic look(input bit [31:0] va, input string req);
    int  idx;
    bit  eh;
    @(negedge clk);
    idle_inputs();
    lk_req = 1'b1;
    lk_va  = va;
    #2;
    eh = m_find(va[31:12], idx);
    chk(lk_hit == eh && lk_miss == !eh, req, {30'd0, lk_hit, lk_miss}, {30'd0, eh, !eh});
    if (eh) chk(lk_pa == {m_ppn[idx], va[11:0]}, req, {2'b0, lk_pa}, {2'b0, m_ppn[idx], va[11:0]});
    chk(lk_pa[11:0] == va[11:0], "R1", {20'd0, lk_pa[11:0]}, {20'd0, va[11:0]});
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [17:0] ppn, input bit fl);
    @(negedge clk);
    idle_inputs();
    fl_en = 1'b1; fl_vpn = vpn; fl_ppn = ppn; flush = fl;
    @(posedge clk);
    #1;
    if (fl) m_reset_keep_ptr();
    else m_fill(vpn, ppn);
  endtask

  function automatic void m_reset_keep_ptr();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    rst = 1'b1;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R5: empty buffer misses everything
    look(32'h0000_0000, "R5");
    look(32'hFFFF_FABC, "R5");
    // R4: no request, no answer
    @(negedge clk);
    idle_inputs();
    lk_va = 32'h1234_5678;
    #2;
    chk(!lk_hit && !lk_miss, "R4", {30'd0, lk_hit, lk_miss}, 32'd0);

    // R3: worked example
    fill(20'h12345, 18'h04321, 1'b0);
    look(32'h1234_5678, "R3");
    chk(lk_pa == 30'h0432_1678, "R3", {2'b0, lk_pa}, 32'h0432_1678);

    // R10: fill not visible in its own cycle
    @(negedge clk);
    idle_inputs();
    fl_en = 1'b1; fl_vpn = 20'hABCDE; fl_ppn = 18'h2AAAA;
    lk_req = 1'b1; lk_va = 32'hABCD_E001;
    #2;
    chk(lk_miss && !lk_hit, "R10", {30'd0, lk_hit, lk_miss}, 32'd1);
    @(posedge clk);
    #1;
    m_fill(20'hABCDE, 18'h2AAAA);
    look(32'hABCD_E001, "R10");

    // R8 and R2: fill to capacity, all slots reachable
    for (int i = 0; i < 6; i++) fill(20'h00100 + 20'(i), 18'(i + 7), 1'b0);
    for (int i = 0; i < 6; i++) look({20'h00100 + 20'(i), 12'h3C3}, "R2");
    look(32'h1234_5000, "R8");

    // R9: replacements walk from slot 0
    fill(20'h00200, 18'h11111, 1'b0);
    look(32'h1234_5678, "R9");
    chk(lk_miss, "R9", {31'd0, lk_miss}, 32'd1);
    fill(20'h00201, 18'h22222, 1'b0);
    look(32'hABCD_E001, "R9");
    chk(lk_miss, "R9", {31'd0, lk_miss}, 32'd1);

    // R7: duplicate fill rewrites in place, nothing evicted
    fill(20'h00102, 18'h3FFFF, 1'b0);
    look({20'h00102, 12'h0F0}, "R7");
    chk(lk_pa == {18'h3FFFF, 12'h0F0}, "R7", {2'b0, lk_pa}, {2'b0, 18'h3FFFF, 12'h0F0});
    for (int i = 0; i < 6; i++) look({20'h00100 + 20'(i), 12'h001}, "R7");
    look(32'h0020_0000, "R7");

    // R6: flush beats a simultaneous fill
    fill(20'h00777, 18'h00777, 1'b1);
    look(32'h0077_7000, "R6");
    chk(lk_miss, "R6", {31'd0, lk_miss}, 32'd1);
    look(32'h0010_0000, "R6");

    // R8 / R9: refill after flush, pointer kept at 2
    for (int i = 0; i < N; i++) fill(20'h00300 + 20'(i), 18'(i + 100), 1'b0);
    fill(20'h00400, 18'h00400, 1'b0);
    look(32'h0030_2000, "R9");
    chk(lk_miss, "R9", {31'd0, lk_miss}, 32'd1);
    look(32'h0030_0000, "R8");
    chk(lk_hit, "R8", {31'd0, lk_hit}, 32'd1);

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 99);
      bit [19:0] v = 20'h50000 + 20'($urandom_range(0, 15));
      if (sel < 3) fill(v, 18'($urandom), 1'b1);
      else if (sel < 40) fill(v, 18'($urandom), 1'b0);
      else look({v, 12'($urandom)}, "R2");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule